// File: doc/BRIEF.md
# Four-Lane Seven-to-One Serial Link Receiver

This block turns four serial data lanes back into a 28-bit parallel word, one word per frame. Each frame lasts seven bit periods. A bit-rate clock running at seven times the frame rate, in phase with the frame clock, comes from a PLL outside the block and arrives as a plain input. The block samples the frame clock on that bit clock. A rising edge of the frame clock marks slot 0 of a new frame. Every lane shifts in one bit per bit period. When the next frame edge arrives after exactly seven slots, the collected word moves into a two-stage pipeline. It then reaches a registered output together with a data-valid flag and an output strobe at the frame rate.

An active-low power-down input forces the outputs low and restarts lock acquisition. After reset or power-up, data is gated until a parameterised number of frame edges has been seen, which models the lock time of the external PLL. If the frame clock stops, the output word and the valid flag keep their last values and the strobe stays low.

Top module: `lvrx_deser`

## Requirements
- R1: Slot k of lane n drives output bit 7*n+k. Slot 0 is the bit sampled on the bit-clock edge where the frame clock is first seen high after being low, and slots 1 to 6 follow on the next six edges.
- R2: The word carried by the frame that starts at frame edge k appears on `data_out` at the bit-clock edge of frame edge k+2. It is held there until the following frame edge.
- R3: While `pd_n` is low, `data_out` is all zeros and `data_valid` and `strobe_out` are low, starting from the first bit-clock edge that samples `pd_n` low.
- R4: After reset release or `pd_n` release, count frame edges from 0. `data_valid` stays low and `data_out` stays zero through edge LOCK_FRAMES-1. At edge LOCK_FRAMES (default 4), `data_valid` rises and `data_out` shows the word of frame LOCK_FRAMES-2.
- R5: While `data_valid` is high, `strobe_out` rises one bit period after each frame edge. It stays high for 3.5 bit periods, which is half the frame, and it is low for the rest of the frame.
- R6: While no frame edge arrives, `data_out` and `data_valid` keep their values and `strobe_out` falls low once the current frame's high window ends.
- R7: While `rst_n` is low, `data_out` is all zeros and `data_valid` and `strobe_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock, seven times the frame rate, phase-aligned to the frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; restarts lock acquisition |
| fclk_in | input | 1 | Frame clock; its rising edge marks slot 0 |
| ser_in | input | LANES (4) | One serial bit per lane per bit period |
| data_out | output | LANES*SLOTS (28) | Recovered parallel word, registered |
| data_valid | output | 1 | High once locked and not in power-down |
| strobe_out | output | 1 | Frame-rate output strobe; its rising edge marks stable data |

## Verification
The bench drives all inputs a quarter period after each rising bit-clock edge and samples a quarter period after the next edge. Each comparison therefore sees the state left by exactly one edge. A behavioural model keeps a queue of sent words and a frame count since the last sync. A new word is due at the edge that starts frame k+2, the valid flag rises at edge LOCK_FRAMES, and the strobe is due high at the samples one to four slots after an edge. Power-down and reset results are due at the first edge that sees them. The model updates its expectation at that same edge and compares data, valid and strobe on every cycle.

// File: rtl/lvrx_pkg.sv
// Shared constants and helpers for the four-lane serial receiver.
package lvrx_pkg;
    localparam int unsigned DEF_LANES       = 4;
    localparam int unsigned DEF_SLOTS       = 7;
    localparam int unsigned DEF_LOCK_FRAMES = 4;

    // Number of whole bit periods the output strobe stays high per frame.
    function automatic int unsigned strobe_full_slots(input int unsigned slots);
        return slots / 2;
    endfunction
endpackage

// File: rtl/lvrx_frame_track.sv
// Frame tracker: detects frame-clock rising edges in the bit-clock domain
// and counts slots since the last edge. Assumes the frame clock is
// phase-aligned so that its rising edge is sampled on slot 0. The slot
// counter parks at an idle value when more than SLOTS bits pass without
// an edge, so a stopped or stretched frame is never reported as complete.
module lvrx_frame_track import lvrx_pkg::*; #(
    parameter int unsigned SLOTS = DEF_SLOTS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fclk_in,
    output logic frame_edge,
    output logic frame_full,
    output logic in_high_window
);
    localparam int unsigned SW   = $clog2(SLOTS + 1);
    localparam logic [SW-1:0] IDLE = SW'(SLOTS);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] HALF = SW'(strobe_full_slots(SLOTS));

    logic          fclk_q;
    logic [SW-1:0] slot_q;

    assign frame_edge     = fclk_in & ~fclk_q;
    assign frame_full     = (slot_q == LAST);
    assign in_high_window = (slot_q < HALF);

    // Track the previous frame-clock level and the slot index since the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_q <= 1'b0;
            slot_q <= IDLE;
        end else begin
            fclk_q <= fclk_in;
            if (frame_edge)
                slot_q <= '0;
            else if (slot_q < IDLE)
                slot_q <= slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/lvrx_lane_shift.sv
// Lane shifters: one SLOTS-bit shift register per lane. Bits enter at the
// top and move down, so after SLOTS shifts the first bit of the frame sits
// at bit 0 of its lane field. The flat word places lane n at bits
// n*SLOTS and up.
module lvrx_lane_shift import lvrx_pkg::*; #(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned SLOTS = DEF_SLOTS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       ser_in,
    output logic [LANES*SLOTS-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SLOTS-1:0] sh_q;

        // Shift one serial bit of this lane in on every bit period.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_q <= '0;
            else
                sh_q <= {ser_in[g], sh_q[SLOTS-1:1]};
        end

        assign word[g*SLOTS +: SLOTS] = sh_q;
    end
endmodule

// File: rtl/lvrx_lock_count.sv
// Lock counter: models the lock time of the external PLL. It counts frame
// edges while powered up and saturates at LOCK_FRAMES. Power-down or reset
// returns it to zero.
module lvrx_lock_count import lvrx_pkg::*; #(
    parameter int unsigned LOCK_FRAMES = DEF_LOCK_FRAMES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic frame_edge,
    output logic lock_done
);
    localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);
    localparam logic [CW-1:0] TARGET = CW'(LOCK_FRAMES);

    logic [CW-1:0] cnt_q;

    assign lock_done = (cnt_q == TARGET);

    // Count frame edges until lock; clear in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n)
            cnt_q <= '0;
        else if (frame_edge && !lock_done)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_done) |-> $past(frame_edge)); // R4

    AST_LOCK_CLEARED_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !lock_done); // R3
endmodule

// File: rtl/lvrx_strobe_gen.sv
// Strobe generator: gives a frame-rate strobe that rises one bit period
// after each frame edge. For an odd slot count, a falling-edge flop adds
// half a bit period so the high time is exactly half the frame. For an
// even slot count the rising-edge flop alone is used.
module lvrx_strobe_gen import lvrx_pkg::*; #(
    parameter int unsigned SLOTS = DEF_SLOTS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic valid_in,
    input  logic in_high_window,
    output logic strobe
);
    logic strobe_p;

    // Rising-edge part: high for the whole-slot part of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_p <= 1'b0;
        else
            strobe_p <= valid_in && pd_n && in_high_window;
    end

    if ((SLOTS % 2) == 1) begin : g_odd
        logic strobe_n;

        // Falling-edge copy that stretches the pulse by half a bit period.
        always_ff @(negedge clk) begin
            if (!rst_n)
                strobe_n <= 1'b0;
            else
                strobe_n <= strobe_p;
        end

        assign strobe = strobe_p | strobe_n;
    end else begin : g_even
        assign strobe = strobe_p;
    end

    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_p |-> valid_in); // R5
endmodule

// File: rtl/lvrx_deser.sv
// Four-lane seven-to-one receiver top. It frames the lane bits on
// frame-clock edges and passes each complete word through two frame-rate
// stages to a registered output. It gates output data until lock and
// forces zero in power-down. Assumes the bit clock is supplied from
// outside, phase-aligned to the frame clock.
module lvrx_deser import lvrx_pkg::*; #(
    parameter int unsigned LANES       = DEF_LANES,
    parameter int unsigned SLOTS       = DEF_SLOTS,
    parameter int unsigned LOCK_FRAMES = DEF_LOCK_FRAMES
) (
    input  logic                   clk_bit,
    input  logic                   rst_n,
    input  logic                   pd_n,
    input  logic                   fclk_in,
    input  logic [LANES-1:0]       ser_in,
    output logic [LANES*SLOTS-1:0] data_out,
    output logic                   data_valid,
    output logic                   strobe_out
);
    localparam int unsigned WORD_W = LANES * SLOTS;

    logic              frame_edge;
    logic              frame_full;
    logic              in_high_window;
    logic              lock_done;
    logic [WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] stage_q;
    logic              stage_ok_q;
    logic [WORD_W-1:0] out_q;
    logic              valid_q;

    lvrx_frame_track #(.SLOTS(SLOTS)) u_track (
        .clk            (clk_bit),
        .rst_n          (rst_n),
        .fclk_in        (fclk_in),
        .frame_edge     (frame_edge),
        .frame_full     (frame_full),
        .in_high_window (in_high_window)
    );

    lvrx_lane_shift #(.LANES(LANES), .SLOTS(SLOTS)) u_shift (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .word   (lane_word)
    );

    lvrx_lock_count #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .clk        (clk_bit),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .frame_edge (frame_edge),
        .lock_done  (lock_done)
    );

    lvrx_strobe_gen #(.SLOTS(SLOTS)) u_strobe (
        .clk            (clk_bit),
        .rst_n          (rst_n),
        .pd_n           (pd_n),
        .valid_in       (valid_q),
        .in_high_window (in_high_window),
        .strobe         (strobe_out)
    );

    // Two-stage frame pipeline: capture on a full frame, publish once locked.
    always_ff @(posedge clk_bit) begin
        if (!rst_n || !pd_n) begin
            stage_q    <= '0;
            stage_ok_q <= 1'b0;
            out_q      <= '0;
            valid_q    <= 1'b0;
        end else if (frame_edge) begin
            stage_q    <= lane_word;
            stage_ok_q <= frame_full;
            if (lock_done && stage_ok_q) begin
                out_q   <= stage_q;
                valid_q <= 1'b1;
            end
        end
    end

    assign data_out   = out_q;
    assign data_valid = valid_q;

    AST_PD_CLEARS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pd_n |=> (data_out == '0) && !data_valid); // R3

    AST_HOLD_NO_FRAME: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (pd_n && !frame_edge) |=> $stable(data_out) && $stable(data_valid)); // R6

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_bit) disable iff (!rst_n)
        data_valid |-> lock_done); // R4

    AST_OUT_ONLY_ON_EDGE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (pd_n && $rose(data_valid)) |-> $past(frame_edge)); // R2
endmodule

// File: tb/lvrx_deser_bench.sv
// Bench for lvrx_deser: serialises words, keeps a behavioural model of the
// expected outputs and compares data, valid and strobe on every bit clock.
module lvrx_deser_bench;
    localparam int LANES = 4;
    localparam int SLOTS = 7;
    localparam int LOCKF = 4;
    localparam int W     = LANES * SLOTS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pd_n = 1'b1;
    logic             fclk = 1'b0;
    logic [LANES-1:0] ser = '0;
    logic [W-1:0]     data_out;
    logic             data_valid;
    logic             strobe_out;

    lvrx_deser #(.LANES(LANES), .SLOTS(SLOTS), .LOCK_FRAMES(LOCKF)) u_lvrx_deser (
        .clk_bit    (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .fclk_in    (fclk),
        .ser_in     (ser),
        .data_out   (data_out),
        .data_valid (data_valid),
        .strobe_out (strobe_out)
    );

    // 50 MHz bit clock: 20 time units per period.
    always #10 clk = ~clk;

    int           tests = 0;
    int           fails = 0;
    string        phase = "R7";
    logic [W-1:0] hist[$];
    int           k = -1;
    int           s = 99;
    logic         prevf = 1'b0;
    logic [W-1:0] exp_data = '0;
    logic         exp_valid = 1'b0;
    logic [W-1:0] cur_word = '0;

    task automatic check(string what, string req, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Update the model for the inputs now applied, clock once, then compare.
    task automatic step();
        logic edge_seen;
        edge_seen = fclk && !prevf;
        prevf = fclk;
        if (!rst_n || !pd_n) begin
            exp_data = '0;
            exp_valid = 1'b0;
            k = -1;
            hist.delete();
        end
        if (!rst_n) begin
            s = 99;
            prevf = 1'b0;
        end else if (edge_seen) begin
            s = 0;
            if (pd_n) begin
                k++;
                hist.push_back(cur_word);
                if (k >= LOCKF) begin
                    exp_data = hist[k-2];
                    exp_valid = 1'b1;
                end
            end
        end else if (s < 99) begin
            s++;
        end
        @(posedge clk);
        #5;
        check("data", (phase == "R2") ? "R1 R2" : phase, data_out, exp_data);
        check("valid", (phase == "R2") ? "R4" : phase, W'(data_valid), W'(exp_valid));
        // R5: strobe high on samples one to four slots after an edge
        check("strobe", "R5", W'(strobe_out),
              W'(exp_valid && rst_n && pd_n && s >= 1 && s <= 4));
    endtask

    task automatic send_frame(logic [W-1:0] w);
        cur_word = w;
        for (int sl = 0; sl < SLOTS; sl++) begin
            fclk = (sl < 4);
            for (int n = 0; n < LANES; n++) ser[n] = w[n*SLOTS + sl];
            step();
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            fclk = 1'b0;
            ser = LANES'($urandom);
            step();
        end
    endtask

    task automatic rand_frames(int n);
        for (int i = 0; i < n; i++) send_frame(W'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R7: reset holds outputs low
        #5;
        rst_n = 1'b0;
        @(posedge clk); #5;
        @(posedge clk); #5;
        phase = "R7";
        idle(5);
        rst_n = 1'b1;
        // R4: lock-up window after reset
        phase = "R4";
        rand_frames(6);
        // R1: single-bit patterns pin lane/slot positions
        phase = "R1";
        send_frame(W'(1) << 0);
        send_frame(W'(1) << 6);
        send_frame(W'(1) << 7);
        send_frame(W'(1) << 13);
        send_frame(W'(1) << 20);
        send_frame(W'(1) << 21);
        send_frame(W'(1) << 27);
        send_frame(28'h0AAAAAA);
        send_frame(28'hFFFFFFF);
        send_frame(28'h0000000);
        // R2: random traffic and latency
        phase = "R2";
        rand_frames(40);
        // R6: frame clock stops, outputs hold
        phase = "R6";
        idle(25);
        // R3: power-down forces zero
        phase = "R3";
        pd_n = 1'b0;
        rand_frames(5);
        // R4: lock again after power-down release
        phase = "R4";
        pd_n = 1'b1;
        rand_frames(8);
        phase = "R2";
        rand_frames(30);
        // R7: reset in mid-stream
        phase = "R7";
        rst_n = 1'b0;
        rand_frames(2);
        rst_n = 1'b1;
        phase = "R4";
        rand_frames(6);
        phase = "R2";
        rand_frames(10);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule